// File: doc/BRIEF.md
# Asynchronous Serial Channel with Error Summary

This block is a full-duplex asynchronous serial channel. Both directions share one character format. A frame has a single low start bit, then 7, 8 or 9 data bits sent least significant bit first. An optional odd or even parity bit follows, and the frame ends with one or two high stop bits. There is no external clock input. All bit timing comes from an internal baud generator. Its count source is the system clock divided by 1, 8, 32 or 256, and a programmable divider then brings that source down to a tick at sixteen times the bit rate.

On the transmit side there is a one-character holding register in front of the shifter. When a character moves from the holding register into the shifter, the block raises a one-cycle request so that a DMA engine can refill the holding register.

The receiver works in these steps:
- It oversamples the line and confirms a start bit at its middle.
- It samples each later bit at its centre.
- It stores the character together with its overrun, parity and framing flags.
- It pulses a receive-complete request.

A summary flag is set whenever any of the three error flags is set. The block can also drive a free-running clock that toggles on every baud tick.

Top module: `async_serial_chan`

## Requirements
- R1: Once reset is released, `txd` is high, `tx_buf_empty` is 1, and `rx_full`, all error flags, `err_sum` and `fclk_out` are 0.
- R2: A transmitted frame is one low start bit followed by the data bits, least significant bit first. `cfg_len` selects the data length: 0 gives 7 bits, 1 gives 8 bits, and 2 or 3 gives 9 bits.
- R3: When `cfg_par_en` is 1, a parity bit follows the data. With `cfg_par_odd`=1 the data bits plus the parity bit hold an odd number of ones; with `cfg_par_odd`=0 they hold an even number.
- R4: When `cfg_two_stop` is 0 the frame ends with one high stop bit, and when it is 1 with two. A character already waiting in the holding register starts right after the last stop bit.
- R5: Every bit lasts 16 × (`cfg_div`+1) × P system clocks. P is selected by `cfg_src`: 0 gives 1, 1 gives 8, 2 gives 32 and 3 gives 256.
- R6: A received character of the configured format appears right-aligned on `rx_data` and sets `rx_full`. On the same edge `rx_done_req` pulses high for one cycle. `rx_read` clears `rx_full`.
- R7: A low pulse on `rxd` shorter than half a bit time does not start a reception.
- R8: If the received parity bit does not match the configured parity, `err_parity` is set together with the stored character.
- R9: If the first stop bit is sampled low, `err_frame` is set together with the character. When two stop bits are configured, the second one is never checked.
- R10: If a character completes while `rx_full` is still 1, `err_overrun` is set and `rx_data` keeps the earlier character.
- R11: `err_sum` is 1 exactly when at least one of `err_overrun`, `err_parity` or `err_frame` is 1. A pulse on `rx_read` or on `err_clear` clears all three flags.
- R12: While `cfg_fclk_en` is 1, `fclk_out` toggles on every baud tick, so its period is two ticks. While it is 0, `fclk_out` is held low.
- R13: `tx_empty_req` pulses for one cycle each time the holding register hands a character to the shifter. A `tx_write` while the holding register is full is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_src | input | 2 | Prescaler select (÷1, ÷8, ÷32, ÷256) |
| cfg_div | input | DIV_W | Baud divider; one tick every cfg_div+1 prescaled counts |
| cfg_len | input | 2 | Character length code |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| cfg_fclk_en | input | 1 | Enables the fixed-cycle clock output |
| tx_data | input | 9 | Character to send, right-aligned |
| tx_write | input | 1 | Load tx_data into the holding register |
| tx_buf_empty | output | 1 | Holding register can accept a character |
| tx_empty_req | output | 1 | One-cycle transmit-empty request |
| txd | output | 1 | Serial output, idles high |
| rxd | input | 1 | Serial input |
| rx_data | output | 9 | Last stored character, right-aligned |
| rx_full | output | 1 | Unread character present |
| rx_read | input | 1 | Consumes the character and clears the error flags |
| err_clear | input | 1 | Clears the error flags only |
| rx_done_req | output | 1 | One-cycle receive-complete request |
| err_overrun | output | 1 | Overrun flag |
| err_parity | output | 1 | Parity error flag |
| err_frame | output | 1 | Framing error flag |
| err_sum | output | 1 | OR of the three error flags |
| fclk_out | output | 1 | Fixed-cycle clock, half the tick rate |

## Verification
- A slip in the transmit bit counter shows on `txd` in the same frame: a bit lands in the wrong mid-bit slot, a parity or stop bit is missing, or the next start comes one bit early.
- A receiver stuck in the wrong state, or a counter out of step with the tick, shows within one character time. The result is a wrong `rx_data` value, a spurious error flag, or a missing `rx_done_req`.
- Flags that fail to clear are caught by reading `err_sum` straight after `rx_read` or `err_clear`.
- A baud divider or prescaler fault changes the measured length of a single bit, or the toggle count of `fclk_out` over a fixed window.

// File: rtl/aser_pkg.sv
package aser_pkg;
  localparam int CHAR_MAX  = 9;
  localparam int OSR       = 16;
  localparam int SUB_W     = $clog2(OSR);
  localparam int FRAME_MAX = CHAR_MAX + 4;

  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP} rx_state_t;

  // data bits per character for a length code
  function automatic logic [3:0] char_bits(input logic [1:0] len);
    case (len)
      2'd0:    return 4'd7;
      2'd1:    return 4'd8;
      default: return 4'd9;
    endcase
  endfunction

  // parity bit value that the sender appends
  function automatic logic par_bit(input logic [CHAR_MAX-1:0] d,
                                   input logic [3:0] nb, input logic odd);
    logic p;
    p = odd;
    for (int i = 0; i < CHAR_MAX; i++)
      if (i < int'(nb)) p = p ^ d[i];
    return p;
  endfunction
endpackage

// File: rtl/aser_baud.sv
module aser_baud #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       src,
  input  logic [DIV_W-1:0] div,
  input  logic             fclk_en,
  output logic             tick,
  output logic             fclk
);
  localparam int PRE_W = 8;

  logic [PRE_W-1:0] pre_cnt, pre_lim;
  logic [DIV_W-1:0] div_cnt;
  logic             pre_hit, div_hit;

  always_comb begin
    case (src)
      2'd0:    pre_lim = 8'd0;
      2'd1:    pre_lim = 8'd7;
      2'd2:    pre_lim = 8'd31;
      default: pre_lim = 8'd255;
    endcase
    pre_hit = (pre_cnt >= pre_lim);
    div_hit = (div_cnt >= div);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_cnt <= '0;
      div_cnt <= '0;
      tick    <= 1'b0;
      fclk    <= 1'b0;
    end else begin
      pre_cnt <= pre_hit ? '0 : pre_cnt + 1'b1;
      tick    <= 1'b0;
      if (pre_hit) begin
        if (div_hit) begin
          div_cnt <= '0;
          tick    <= 1'b1;
        end else begin
          div_cnt <= div_cnt + 1'b1;
        end
      end
      fclk <= fclk_en ? (fclk ^ tick) : 1'b0;
    end
  end

  assert_fclk_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (fclk_en && !tick) |=> $stable(fclk));
endmodule

// File: rtl/aser_tx.sv
module aser_tx
  import aser_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic [1:0]          len,
  input  logic                par_en,
  input  logic                par_odd,
  input  logic                two_stop,
  input  logic [CHAR_MAX-1:0] wdata,
  input  logic                write,
  output logic                txd,
  output logic                buf_empty,
  output logic                empty_req
);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OSR - 1);

  logic [CHAR_MAX-1:0]  hold_q;
  logic                 hold_full;
  logic [FRAME_MAX-1:0] frame_q, frame_n;
  logic [3:0]           left_q, total_n, nb;
  logic [SUB_W-1:0]     sub_q;

  // assemble start, data, parity and stop bits; unused top bits stay high
  always_comb begin
    nb      = char_bits(len);
    frame_n = '1;
    frame_n[0] = 1'b0;
    for (int i = 0; i < CHAR_MAX; i++)
      if (i < int'(nb)) frame_n[i+1] = hold_q[i];
    if (par_en) frame_n[4'(nb + 4'd1)] = par_bit(hold_q, nb, par_odd);
    total_n = 4'd2 + nb + {3'd0, par_en} + {3'd0, two_stop};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
      frame_q   <= '1;
      left_q    <= '0;
      sub_q     <= '0;
      txd       <= 1'b1;
      empty_req <= 1'b0;
    end else begin
      empty_req <= 1'b0;
      if (write && !hold_full) begin
        hold_q    <= wdata;
        hold_full <= 1'b1;
      end
      if (left_q == 4'd0) begin
        if (hold_full) begin
          frame_q   <= frame_n;
          left_q    <= total_n;
          sub_q     <= '0;
          hold_full <= 1'b0;
          empty_req <= 1'b1;
          txd       <= 1'b0;
        end
      end else if (tick) begin
        if (sub_q == SUB_LAST) begin
          sub_q   <= '0;
          frame_q <= {1'b1, frame_q[FRAME_MAX-1:1]};
          left_q  <= left_q - 4'd1;
          txd     <= (left_q > 4'd1) ? frame_q[1] : 1'b1;
        end else begin
          sub_q <= sub_q + 1'b1;
        end
      end
    end
  end

  assign buf_empty = !hold_full;

  assert_start_low_R2: assert property (@(posedge clk) disable iff (rst)
    empty_req |-> !txd);
  assert_idle_high_R4: assert property (@(posedge clk) disable iff (rst)
    (left_q == 4'd0) |-> txd);
  assert_hold_kept_R13: assert property (@(posedge clk) disable iff (rst)
    hold_full |=> $stable(hold_q));
endmodule

// File: rtl/aser_rx.sv
module aser_rx
  import aser_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic [1:0]          len,
  input  logic                par_en,
  input  logic                par_odd,
  input  logic                rxd,
  input  logic                rd,
  input  logic                clr,
  output logic [CHAR_MAX-1:0] data_q,
  output logic                full_q,
  output logic                done_q,
  output logic                ov_q,
  output logic                pe_q,
  output logic                fe_q,
  output logic                sum_q
);
  localparam logic [SUB_W-1:0] SUB_MID  = SUB_W'(OSR / 2 - 1);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OSR - 1);

  logic                rs1, rs2, last_q, pbit, fin;
  rx_state_t           st;
  logic [SUB_W-1:0]    sub;
  logic [3:0]          got, nb;
  logic [CHAR_MAX-1:0] sh, rdata, data_n;
  logic                full_n, ov_n, pe_n, fe_n, done_n;

  always_comb begin
    nb    = char_bits(len);
    rdata = sh >> (4'(CHAR_MAX) - nb);
    fin   = tick && (st == RX_STOP) && (sub == SUB_LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rs1 <= 1'b1; rs2 <= 1'b1; last_q <= 1'b1;
      st  <= RX_IDLE; sub <= '0; got <= '0; sh <= '0; pbit <= 1'b0;
    end else begin
      rs1 <= rxd;
      rs2 <= rs1;
      if (tick) begin
        last_q <= rs2;
        case (st)
          RX_IDLE:
            if (last_q && !rs2) begin
              st  <= RX_START;
              sub <= '0;
            end
          RX_START:
            if (sub == SUB_MID) begin
              sub <= '0;
              got <= '0;
              st  <= rs2 ? RX_IDLE : RX_DATA;
            end else sub <= sub + 1'b1;
          RX_DATA:
            if (sub == SUB_LAST) begin
              sub <= '0;
              sh  <= {rs2, sh[CHAR_MAX-1:1]};
              got <= got + 4'd1;
              if (got == nb - 4'd1) st <= par_en ? RX_PAR : RX_STOP;
            end else sub <= sub + 1'b1;
          RX_PAR:
            if (sub == SUB_LAST) begin
              sub  <= '0;
              pbit <= rs2;
              st   <= RX_STOP;
            end else sub <= sub + 1'b1;
          RX_STOP:
            if (sub == SUB_LAST) st <= RX_IDLE;
            else sub <= sub + 1'b1;
          default: st <= RX_IDLE;
        endcase
      end
    end
  end

  // holding register and flags: clears first, a completed character overrides
  always_comb begin
    data_n = data_q; full_n = full_q; ov_n = ov_q; pe_n = pe_q; fe_n = fe_q;
    done_n = 1'b0;
    if (rd) begin
      full_n = 1'b0; ov_n = 1'b0; pe_n = 1'b0; fe_n = 1'b0;
    end
    if (clr) begin
      ov_n = 1'b0; pe_n = 1'b0; fe_n = 1'b0;
    end
    if (fin) begin
      if (full_n) ov_n = 1'b1;
      else begin
        data_n = rdata;
        full_n = 1'b1;
        pe_n   = par_en && (pbit != par_bit(rdata, nb, par_odd));
        fe_n   = !rs2;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0; full_q <= 1'b0; done_q <= 1'b0;
      ov_q <= 1'b0; pe_q <= 1'b0; fe_q <= 1'b0; sum_q <= 1'b0;
    end else begin
      data_q <= data_n; full_q <= full_n; done_q <= done_n;
      ov_q <= ov_n; pe_q <= pe_n; fe_q <= fe_n;
      sum_q <= ov_n | pe_n | fe_n;
    end
  end

  assert_sum_or_R11: assert property (@(posedge clk) disable iff (rst)
    sum_q == (ov_q | pe_q | fe_q));
  assert_done_full_R6: assert property (@(posedge clk) disable iff (rst)
    done_q |-> full_q);
  assert_overrun_keep_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(ov_q) |-> (full_q && $stable(data_q)));
  assert_frame_with_char_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(fe_q) |-> done_q);
endmodule

// File: rtl/async_serial_chan.sv
module async_serial_chan
  import aser_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          cfg_src,
  input  logic [DIV_W-1:0]    cfg_div,
  input  logic [1:0]          cfg_len,
  input  logic                cfg_par_en,
  input  logic                cfg_par_odd,
  input  logic                cfg_two_stop,
  input  logic                cfg_fclk_en,
  input  logic [CHAR_MAX-1:0] tx_data,
  input  logic                tx_write,
  output logic                tx_buf_empty,
  output logic                tx_empty_req,
  output logic                txd,
  input  logic                rxd,
  output logic [CHAR_MAX-1:0] rx_data,
  output logic                rx_full,
  input  logic                rx_read,
  input  logic                err_clear,
  output logic                rx_done_req,
  output logic                err_overrun,
  output logic                err_parity,
  output logic                err_frame,
  output logic                err_sum,
  output logic                fclk_out
);
  logic tick;

  aser_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst(rst), .src(cfg_src), .div(cfg_div),
    .fclk_en(cfg_fclk_en), .tick(tick), .fclk(fclk_out)
  );

  aser_tx u_tx (
    .clk(clk), .rst(rst), .tick(tick), .len(cfg_len), .par_en(cfg_par_en),
    .par_odd(cfg_par_odd), .two_stop(cfg_two_stop), .wdata(tx_data),
    .write(tx_write), .txd(txd), .buf_empty(tx_buf_empty),
    .empty_req(tx_empty_req)
  );

  aser_rx u_rx (
    .clk(clk), .rst(rst), .tick(tick), .len(cfg_len), .par_en(cfg_par_en),
    .par_odd(cfg_par_odd), .rxd(rxd), .rd(rx_read), .clr(err_clear),
    .data_q(rx_data), .full_q(rx_full), .done_q(rx_done_req),
    .ov_q(err_overrun), .pe_q(err_parity), .fe_q(err_frame), .sum_q(err_sum)
  );
endmodule

// File: tb/async_serial_chan_test.sv
`timescale 1ns/1ps
module async_serial_chan_test;
  localparam int DIV_W = 12;

  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] cfg_src = 2'd0, cfg_len = 2'd1;
  logic [DIV_W-1:0] cfg_div = '0;
  logic cfg_par_en = 0, cfg_par_odd = 0, cfg_two_stop = 0, cfg_fclk_en = 0;
  logic [8:0] tx_data = '0, rx_data;
  logic tx_write = 0, rx_read = 0, err_clear = 0, rxd_drv = 1, loop = 0;
  logic tx_buf_empty, tx_empty_req, txd, rx_full, rx_done_req;
  logic err_overrun, err_parity, err_frame, err_sum, fclk_out, rxd;

  int errs = 0, checks = 0, done_cnt = 0, req_cnt = 0;

  always #2.5 clk = ~clk;
  assign rxd = loop ? txd : rxd_drv;

  async_serial_chan #(.DIV_W(DIV_W)) uut (
    .clk(clk), .rst(rst), .cfg_src(cfg_src), .cfg_div(cfg_div), .cfg_len(cfg_len),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_two_stop(cfg_two_stop),
    .cfg_fclk_en(cfg_fclk_en), .tx_data(tx_data), .tx_write(tx_write),
    .tx_buf_empty(tx_buf_empty), .tx_empty_req(tx_empty_req), .txd(txd), .rxd(rxd),
    .rx_data(rx_data), .rx_full(rx_full), .rx_read(rx_read), .err_clear(err_clear),
    .rx_done_req(rx_done_req), .err_overrun(err_overrun), .err_parity(err_parity),
    .err_frame(err_frame), .err_sum(err_sum), .fclk_out(fclk_out)
  );

  always @(negedge clk) begin
    if (rx_done_req) done_cnt++;
    if (tx_empty_req) req_cnt++;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int bp();
    int p;
    case (cfg_src) 2'd0: p = 1; 2'd1: p = 8; 2'd2: p = 32; default: p = 256; endcase
    return 16 * (int'(cfg_div) + 1) * p;
  endfunction

  function automatic int nbits();
    return (cfg_len == 2'd0) ? 7 : (cfg_len == 2'd1) ? 8 : 9;
  endfunction

  function automatic int flen();
    return 2 + nbits() + int'(cfg_par_en) + int'(cfg_two_stop);
  endfunction

  // expected frame, bit 0 first on the line
  function automatic logic [12:0] mk(input logic [8:0] d, input bit badp, input bit badstop);
    logic [12:0] f = '1;
    logic p = cfg_par_odd;
    int nb = nbits();
    f[0] = 1'b0;
    for (int i = 0; i < nb; i++) begin f[i+1] = d[i]; p ^= d[i]; end
    if (cfg_par_en) f[nb+1] = p ^ badp;
    if (badstop) f[nb + 1 + int'(cfg_par_en)] = 1'b0;
    return f;
  endfunction

  task automatic write_tx(input logic [8:0] d);
    tx_data = d; tx_write = 1; wcyc(1); tx_write = 0;
  endtask

  task automatic pulse_read();
    rx_read = 1; wcyc(1); rx_read = 0; wcyc(1);
  endtask

  task automatic rx_send(input logic [12:0] f, input int n);
    for (int i = 0; i < n; i++) begin rxd_drv = f[i]; wcyc(bp()); end
    rxd_drv = 1'b1;
    wcyc(2);
  endtask

  // wait for a start bit, then sample n bits at their centres
  task automatic tx_cap(input int n, output logic [12:0] b);
    b = '1;
    while (txd) @(negedge clk);
    wcyc(bp() / 2);
    for (int i = 0; i < n; i++) begin
      b[i] = txd;
      if (i < n - 1) wcyc(bp());
    end
  endtask

  task automatic cmp_frame(input string tag, input logic [12:0] got, input logic [12:0] exp, input int n);
    logic [12:0] m = 13'((1 << n) - 1);
    chk(tag, int'(got & m), int'(exp & m));
  endtask

  task automatic t_reset();
    chk("R1 txd idle", txd, 1);
    chk("R1 tx_buf_empty", tx_buf_empty, 1);
    chk("R1 rx_full", rx_full, 0);
    chk("R1 err_sum", err_sum, 0);
    chk("R1 fclk_out", fclk_out, 0);
  endtask

  task automatic t_tx_formats();
    logic [12:0] b;
    cfg_len = 2'd1; cfg_par_en = 0;
    write_tx(9'h0A5); tx_cap(flen(), b);
    cmp_frame("R2 tx 8-bit frame", b, mk(9'h0A5, 0, 0), flen()); wcyc(bp() * 2);
    cfg_len = 2'd0; cfg_par_en = 1; cfg_par_odd = 0;
    write_tx(9'h05B); tx_cap(flen(), b);
    cmp_frame("R3 tx 7-bit even parity", b, mk(9'h05B, 0, 0), flen()); wcyc(bp() * 2);
    cfg_len = 2'd2; cfg_par_odd = 1;
    write_tx(9'h1C3); tx_cap(flen(), b);
    cmp_frame("R2 R3 tx 9-bit odd parity", b, mk(9'h1C3, 0, 0), flen()); wcyc(bp() * 2);
    cfg_len = 2'd1; cfg_par_en = 0; cfg_par_odd = 0;
  endtask

  task automatic t_stops();
    logic [12:0] b;
    cfg_two_stop = 1;
    write_tx(9'h0F0); wcyc(2); write_tx(9'h00F);
    tx_cap(flen(), b);
    chk("R4 second stop high", b[10], 1);
    wcyc(bp());
    chk("R4 next start after two stops", txd, 0);
    wcyc(bp() * 14);
    cfg_two_stop = 0;
    write_tx(9'h0F0); wcyc(2); write_tx(9'h00F);
    tx_cap(flen(), b);
    chk("R4 single stop high", b[9], 1);
    wcyc(bp());
    chk("R4 next start after one stop", txd, 0);
    wcyc(bp() * 14);
  endtask

  task automatic t_rate();
    int cnt = 0;
    cfg_src = 2'd1; cfg_div = 12'd1;
    wcyc(300);
    write_tx(9'h001);
    while (txd) @(negedge clk);
    while (!txd) @(negedge clk);
    while (txd) begin @(negedge clk); cnt++; end
    chk("R5 bit length src=1 div=1", cnt, 256);
    wcyc(bp() * 10);
    cfg_src = 2'd0; cfg_div = '0;
    wcyc(50);
  endtask

  task automatic t_rx();
    int d0 = done_cnt;
    rx_send(mk(9'h03C, 0, 0), flen());
    chk("R6 rx_full", rx_full, 1);
    chk("R6 rx_data", int'(rx_data), 'h3C);
    chk("R6 rx_done_req pulses", done_cnt - d0, 1);
    chk("R6 no error", err_sum, 0);
    pulse_read();
    chk("R6 rx_read clears full", rx_full, 0);
  endtask

  task automatic t_glitch();
    int d0 = done_cnt;
    rxd_drv = 0; wcyc(5); rxd_drv = 1;
    wcyc(bp() * 12);
    chk("R7 glitch no char", done_cnt - d0, 0);
    chk("R7 glitch rx_full", rx_full, 0);
  endtask

  task automatic t_parity();
    cfg_par_en = 1; cfg_par_odd = 0;
    rx_send(mk(9'h0C7, 1, 0), flen());
    chk("R8 err_parity", err_parity, 1);
    chk("R8 data kept", int'(rx_data), 'hC7);
    chk("R11 err_sum on parity", err_sum, 1);
    err_clear = 1; wcyc(1); err_clear = 0; wcyc(1);
    chk("R11 err_clear clears sum", err_sum, 0);
    chk("R11 err_clear keeps char", rx_full, 1);
    pulse_read();
    rx_send(mk(9'h0C7, 0, 0), flen());
    chk("R8 good parity no flag", err_parity, 0);
    pulse_read();
    cfg_par_en = 0;
  endtask

  task automatic t_frame();
    cfg_two_stop = 1;
    rx_send(mk(9'h081, 0, 1), flen());
    chk("R9 err_frame", err_frame, 1);
    chk("R9 data", int'(rx_data), 'h81);
    pulse_read();
    chk("R11 read clears frame", err_sum, 0);
    begin
      logic [12:0] f = mk(9'h042, 0, 0);
      f[10] = 1'b0;
      rx_send(f, 10);
      chk("R9 second stop unchecked", err_frame, 0);
      wcyc(bp() * 12);
      pulse_read();
    end
    cfg_two_stop = 0;
  endtask

  task automatic t_overrun();
    rx_send(mk(9'h011, 0, 0), flen());
    rx_send(mk(9'h022, 0, 0), flen());
    chk("R10 err_overrun", err_overrun, 1);
    chk("R10 old data kept", int'(rx_data), 'h11);
    chk("R11 err_sum on overrun", err_sum, 1);
    pulse_read();
    chk("R11 read clears overrun", err_overrun + err_sum, 0);
  endtask

  task automatic t_loop();
    cfg_len = 2'd2; cfg_par_en = 1; cfg_par_odd = 1; cfg_two_stop = 1; loop = 1;
    write_tx(9'h1A5);
    wcyc(bp() * 15);
    chk("R6 loopback 9-bit data", int'(rx_data), 'h1A5);
    chk("R6 loopback no error", err_sum, 0);
    pulse_read();
    loop = 0; cfg_len = 2'd1; cfg_par_en = 0; cfg_par_odd = 0; cfg_two_stop = 0;
  endtask

  task automatic t_fclk();
    int n = 0;
    logic prev;
    cfg_fclk_en = 1; wcyc(4);
    prev = fclk_out;
    for (int i = 0; i < 40; i++) begin wcyc(1); if (fclk_out != prev) n++; prev = fclk_out; end
    chk("R12 toggles div=0", n, 40);
    cfg_div = 12'd3; wcyc(8); n = 0; prev = fclk_out;
    for (int i = 0; i < 40; i++) begin wcyc(1); if (fclk_out != prev) n++; prev = fclk_out; end
    chk("R12 toggles div=3", n, 10);
    cfg_fclk_en = 0; wcyc(2); n = 0;
    for (int i = 0; i < 20; i++) begin wcyc(1); n += int'(fclk_out); end
    chk("R12 disabled low", n, 0);
    cfg_div = '0; wcyc(8);
  endtask

  task automatic t_txbuf();
    logic [12:0] b;
    int r0 = req_cnt;
    write_tx(9'h055); wcyc(2);
    write_tx(9'h066);
    chk("R13 buffer full", tx_buf_empty, 0);
    write_tx(9'h077);
    tx_cap(flen(), b);
    cmp_frame("R13 first char", b, mk(9'h055, 0, 0), flen());
    tx_cap(flen(), b);
    cmp_frame("R13 second char not overwritten", b, mk(9'h066, 0, 0), flen());
    wcyc(bp() * 12);
    chk("R13 no third char", txd, 1);
    chk("R13 empty requests", req_cnt - r0, 2);
  endtask

  initial begin
    wcyc(150000);
    errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    wcyc(4);
    rst = 0;
    wcyc(2);
    t_reset();
    t_tx_formats();
    t_stops();
    t_rate();
    t_rx();
    t_glitch();
    t_parity();
    t_frame();
    t_overrun();
    t_loop();
    t_fclk();
    t_txbuf();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule